// File: doc/BRIEF.md
# Audio Master Clock Ratio Generator

This block runs in clock-master mode and turns an audio master clock into the serial bit clock and the frame (sample-rate) clock. Three inputs pick the configuration: the interface format, the speed mode and the ratio between the master clock and the frame clock. A legality table over format and speed mode decides whether the combination is supported and, if it is, which division factors apply. Both output clocks are built from the master clock and stay phase-locked to it. When a ratio has a factor of three, the bit clock divides by 1.5, 3 or 6. To do that, it uses a stage driven by the falling edge of the master clock.

An unsupported combination raises an error flag and keeps both clocks idle. A configuration change while running mutes both clocks until the current frame ends. The new setting then starts at the first bit of a fresh frame, so the receiver never sees a runt bit or a runt frame.

Top module: `audclk_ratio_gen`

## Requirements
- R1: For the standard formats (fmt 0 = I2S, 1 = left-justified, 2 = right-justified), each frame contains exactly 64 bit-clock periods in every speed mode.
- R2: One-line mode 1 (fmt 3) gives 128 bit-clock periods per frame. One-line mode 2 (fmt 4) gives 256.
- R3: The frame length in master-clock cycles is the speed base times a multiplier. The speed base is 256 for spd 0 (single), 128 for spd 1 (double) and 64 for spd 2 (quad). The multiplier comes from rsel: 0 gives ×1, 1 gives ×1.5, 2 gives ×2, 3 gives ×3 and 4 gives ×4.
- R4: The frame clock is low for the first half of each frame and high for the second half. It falls at the frame start, on the same master-clock rising edge at which the bit clock rises.
- R5: When the bit-clock period is an even number of master-clock half-periods, the bit clock has a 50% duty cycle, and this includes divide-by-3. For divide-by-1.5 it is high for one full master-clock period and low for one half-period.
- R6: The one-line modes are illegal in quad speed. In double speed they are legal only with rsel 2, 3 or 4.
- R7: TDM (fmt 5) is illegal, because this block only acts as clock master. Also illegal are fmt 6 and 7, spd 3 and rsel 5 to 7.
- R8: err_o is registered. It reflects the configuration sampled at the previous rising edge of the master clock.
- R9: While err_o is high, bclk_o and fclk_o are low.
- R10: A configuration change seen while running holds both clocks low from the next rising edge until the current frame ends. The new setting then starts at frame position 0. If the change is seen on the last cycle of a frame, the switch happens with no gap.
- R11: In reset all outputs are low. The first rising edge after reset loads the configuration and, if it is legal, starts a frame at position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fmt_i | input | 3 | Interface format code |
| spd_i | input | 2 | Speed mode code |
| rsel_i | input | 3 | Master-to-frame ratio select |
| bclk_o | output | 1 | Bit clock |
| fclk_o | output | 1 | Frame clock |
| err_o | output | 1 | Illegal configuration flag |

## Verification
The hardest situation to reach from the ports is a configuration change that lands exactly on the last master-clock cycle of a frame. That is the only case where the block must switch straight to the new setting without a muted gap. The bench follows the frame position in its reference model, steps one cycle at a time until that position is the final one, and only then changes the inputs. It then checks that the bit clock is high on the very next half-period. Odd divide paths (1.5 and 3) and changes that land in the middle of a frame are also driven, so both edges of the falling-edge stage are exercised.

// File: rtl/audclk_pkg.sv
package audclk_pkg;
  typedef enum logic [2:0] {
    FMT_I2S  = 3'd0,
    FMT_LJ   = 3'd1,
    FMT_RJ   = 3'd2,
    FMT_OLM1 = 3'd3,
    FMT_OLM2 = 3'd4,
    FMT_TDM  = 3'd5
  } fmt_e;

  typedef enum logic [1:0] {
    SPD_SINGLE = 2'd0,
    SPD_DOUBLE = 2'd1,
    SPD_QUAD   = 2'd2
  } spd_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2
  } st_e;

  typedef struct packed {
    logic [2:0] fmt;
    logic [1:0] spd;
    logic [2:0] rsel;
  } cfg_t;

  localparam int unsigned RSEL_MAX = 4;
endpackage

// File: rtl/audclk_cfg_check.sv
module audclk_cfg_check
  import audclk_pkg::*;
(
  input  cfg_t cfg_i,
  output logic legal_o
);
  logic olm;
  logic fmt_ok, spd_ok, rsel_ok;

  always_comb begin
    olm     = (cfg_i.fmt == FMT_OLM1) || (cfg_i.fmt == FMT_OLM2);
    fmt_ok  = (cfg_i.fmt <= FMT_OLM2);
    spd_ok  = (cfg_i.spd <= SPD_QUAD);
    rsel_ok = (32'(cfg_i.rsel) <= RSEL_MAX);
    legal_o = fmt_ok && spd_ok && rsel_ok;
    if (olm && cfg_i.spd == SPD_QUAD) legal_o = 1'b0;
    if (olm && cfg_i.spd == SPD_DOUBLE && cfg_i.rsel < 3'd2) legal_o = 1'b0;
  end
endmodule

// File: rtl/audclk_ratio_decode.sv
module audclk_ratio_decode
  import audclk_pkg::*;
#(
  parameter int unsigned SS_BASE   = 256,
  parameter int unsigned STD_BITS  = 64,
  parameter int unsigned OLM1_BITS = 128,
  parameter int unsigned OLM2_BITS = 256,
  parameter int unsigned RW        = 11,
  parameter int unsigned PW        = 6
) (
  input  cfg_t          cfg_i,
  output logic [RW-1:0] ratio_o,
  output logic [PW-1:0] per_o,
  output logic [PW-1:0] hi_o
);
  int unsigned base, rat, per;

  always_comb begin
    case (cfg_i.spd)
      SPD_DOUBLE: base = SS_BASE / 2;
      SPD_QUAD:   base = SS_BASE / 4;
      default:    base = SS_BASE;
    endcase
    case (cfg_i.rsel)
      3'd1:    rat = base + base / 2;
      3'd2:    rat = base * 2;
      3'd3:    rat = base * 3;
      3'd4:    rat = base * 4;
      default: rat = base;
    endcase
    // period in master-clock half cycles
    case (cfg_i.fmt)
      FMT_OLM1: per = (2 * rat) / OLM1_BITS;
      FMT_OLM2: per = (2 * rat) / OLM2_BITS;
      default:  per = (2 * rat) / STD_BITS;
    endcase
    if (per < 2) per = 2;
    ratio_o = RW'(rat);
    per_o   = PW'(per);
    hi_o    = PW'((per + 1) / 2);
  end
endmodule

// File: rtl/audclk_seq.sv
module audclk_seq
  import audclk_pkg::*;
#(
  parameter int unsigned CNT_W = 10,
  parameter int unsigned RW    = 11,
  parameter int unsigned PW    = 6
) (
  input  logic          mclk_i,
  input  logic          rst_ni,
  input  cfg_t          cfg_i,
  input  logic          legal_i,
  input  logic [RW-1:0] ratio_i,
  input  logic [PW-1:0] per_i,
  input  logic [PW-1:0] hi_i,
  output cfg_t          act_o,
  output logic          run_o,
  output logic          drain_o,
  output logic [PW-1:0] bpos_o,
  output logic          bclk_hi_o,
  output logic          fclk_o,
  output logic          err_o
);
  st_e              st_q, st_n;
  cfg_t             act_q, act_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [PW-1:0]    b_q, b_n;
  logic [PW:0]      b2;
  logic             wrap, chg, run_n;

  assign wrap = ({1'b0, cnt_q} == (ratio_i - 1'b1));
  assign chg  = (cfg_i != act_q);

  always_comb begin
    st_n  = st_q;
    act_n = act_q;
    cnt_n = wrap ? '0 : cnt_q + 1'b1;
    b2    = {1'b0, b_q} + (PW+1)'(2);
    b_n   = (b2 >= {1'b0, per_i}) ? PW'(b2 - {1'b0, per_i}) : b2[PW-1:0];
    case (st_q)
      ST_IDLE: begin
        act_n = cfg_i;
        cnt_n = '0;
        b_n   = '0;
        st_n  = legal_i ? ST_RUN : ST_IDLE;
      end
      default: begin
        if (wrap && (st_q == ST_DRAIN || chg)) begin
          // frame boundary: adopt the pending setting
          act_n = cfg_i;
          cnt_n = '0;
          b_n   = '0;
          st_n  = legal_i ? ST_RUN : ST_IDLE;
        end else if (st_q == ST_RUN && chg) begin
          st_n = ST_DRAIN;
        end
      end
    endcase
    run_n = (st_n == ST_RUN);
  end

  always_ff @(posedge mclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      act_q     <= '0;
      cnt_q     <= '0;
      b_q       <= '0;
      bclk_hi_o <= 1'b0;
      fclk_o    <= 1'b0;
      err_o     <= 1'b0;
    end else begin
      st_q      <= st_n;
      act_q     <= act_n;
      cnt_q     <= cnt_n;
      b_q       <= b_n;
      bclk_hi_o <= run_n && (b_n < hi_i);
      fclk_o    <= run_n && ({1'b0, cnt_n} >= (ratio_i >> 1));
      err_o     <= ~legal_i;
    end
  end

  assign act_o   = act_q;
  assign run_o   = (st_q == ST_RUN);
  assign drain_o = (st_q == ST_DRAIN);
  assign bpos_o  = b_q;
endmodule

// File: rtl/audclk_edge_gen.sv
module audclk_edge_gen #(
  parameter int unsigned PW = 6
) (
  input  logic          mclk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [PW-1:0] bpos_i,
  input  logic [PW-1:0] per_i,
  input  logic [PW-1:0] hi_i,
  input  logic          bclk_hi_i,
  output logic          bclk_o
);
  logic [PW:0]   b1;
  logic [PW-1:0] idx;
  logic          bclk_lo_q;

  always_comb begin
    b1  = {1'b0, bpos_i} + 1'b1;
    idx = (b1 == {1'b0, per_i}) ? '0 : b1[PW-1:0];
  end

  // low-phase half step, needed for odd half-cycle periods and div-3 duty
  always_ff @(negedge mclk_i or negedge rst_ni) begin
    if (!rst_ni) bclk_lo_q <= 1'b0;
    else         bclk_lo_q <= run_i && (idx < hi_i);
  end

  assign bclk_o = mclk_i ? bclk_hi_i : bclk_lo_q;
endmodule

// File: rtl/audclk_ratio_gen.sv
module audclk_ratio_gen
  import audclk_pkg::*;
#(
  parameter int unsigned SS_BASE   = 256,
  parameter int unsigned STD_BITS  = 64,
  parameter int unsigned OLM1_BITS = 128,
  parameter int unsigned OLM2_BITS = 256,
  parameter int unsigned MAX_RATIO = 1024
) (
  input  logic       mclk_i,
  input  logic       rst_ni,
  input  logic [2:0] fmt_i,
  input  logic [1:0] spd_i,
  input  logic [2:0] rsel_i,
  output logic       bclk_o,
  output logic       fclk_o,
  output logic       err_o
);
  localparam int unsigned CNT_W = $clog2(MAX_RATIO);
  localparam int unsigned RW    = CNT_W + 1;
  localparam int unsigned PW    = $clog2(2 * MAX_RATIO / STD_BITS) + 1;

  cfg_t          cfg_in, act_cfg;
  logic          legal_in;
  logic [RW-1:0] ratio_act;
  logic [PW-1:0] per_act, hi_act, bpos_w;
  logic          run_w, drain_w, bclk_hi_w;

  assign cfg_in = '{fmt: fmt_i, spd: spd_i, rsel: rsel_i};

  audclk_cfg_check u_chk_in (
    .cfg_i  (cfg_in),
    .legal_o(legal_in)
  );

  audclk_ratio_decode #(
    .SS_BASE  (SS_BASE),
    .STD_BITS (STD_BITS),
    .OLM1_BITS(OLM1_BITS),
    .OLM2_BITS(OLM2_BITS),
    .RW       (RW),
    .PW       (PW)
  ) u_dec (
    .cfg_i  (act_cfg),
    .ratio_o(ratio_act),
    .per_o  (per_act),
    .hi_o   (hi_act)
  );

  audclk_seq #(
    .CNT_W(CNT_W),
    .RW   (RW),
    .PW   (PW)
  ) u_seq (
    .mclk_i   (mclk_i),
    .rst_ni   (rst_ni),
    .cfg_i    (cfg_in),
    .legal_i  (legal_in),
    .ratio_i  (ratio_act),
    .per_i    (per_act),
    .hi_i     (hi_act),
    .act_o    (act_cfg),
    .run_o    (run_w),
    .drain_o  (drain_w),
    .bpos_o   (bpos_w),
    .bclk_hi_o(bclk_hi_w),
    .fclk_o   (fclk_o),
    .err_o    (err_o)
  );

  audclk_edge_gen #(
    .PW(PW)
  ) u_edge (
    .mclk_i   (mclk_i),
    .rst_ni   (rst_ni),
    .run_i    (run_w),
    .bpos_i   (bpos_w),
    .per_i    (per_act),
    .hi_i     (hi_act),
    .bclk_hi_i(bclk_hi_w),
    .bclk_o   (bclk_o)
  );
endmodule

// File: rtl/audclk_ratio_gen_chk.sv
module audclk_ratio_gen_chk
  import audclk_pkg::*;
(
  input logic       mclk_i,
  input logic       rst_ni,
  input logic [2:0] fmt_i,
  input logic [1:0] spd_i,
  input logic [2:0] rsel_i,
  input logic       bclk_o,
  input logic       fclk_o,
  input logic       err_o,
  input logic       drain_i
);
  logic up_q;
  logic rsel_hi;

  assign rsel_hi = (rsel_i > 3'd4);

  always_ff @(posedge mclk_i or negedge rst_ni) begin
    if (!rst_ni) up_q <= 1'b0;
    else         up_q <= 1'b1;
  end

  // R9
  err_idle_chk: assert property (@(posedge mclk_i) disable iff (!rst_ni)
    err_o |-> (!fclk_o && !bclk_o));

  // R9
  err_idle_hi_chk: assert property (@(negedge mclk_i) disable iff (!rst_ni)
    err_o |-> !bclk_o);

  // R7
  tdm_err_chk: assert property (@(posedge mclk_i) disable iff (!rst_ni)
    (up_q && $past(fmt_i) == FMT_TDM) |-> err_o);

  // R7
  rsel_err_chk: assert property (@(posedge mclk_i) disable iff (!rst_ni)
    (up_q && $past(rsel_hi)) |-> err_o);

  // R6
  olm_quad_err_chk: assert property (@(posedge mclk_i) disable iff (!rst_ni)
    (up_q && ($past(fmt_i) == FMT_OLM1 || $past(fmt_i) == FMT_OLM2)
          && $past(spd_i) == SPD_QUAD) |-> err_o);

  // R10
  drain_mute_chk: assert property (@(posedge mclk_i) disable iff (!rst_ni)
    drain_i |-> (!fclk_o && !bclk_o));
endmodule

bind audclk_ratio_gen audclk_ratio_gen_chk u_prop (
  .mclk_i (mclk_i),
  .rst_ni (rst_ni),
  .fmt_i  (fmt_i),
  .spd_i  (spd_i),
  .rsel_i (rsel_i),
  .bclk_o (bclk_o),
  .fclk_o (fclk_o),
  .err_o  (err_o),
  .drain_i(drain_w)
);

// File: tb/sim_audclk_ratio_gen.sv
module sim_audclk_ratio_gen;
  localparam int CLK_P = 20;

  logic       mclk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] fmt = 3'd0;
  logic [1:0] spd = 2'd0;
  logic [2:0] rsel = 3'd0;
  logic       bclk, fclk, err;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // reference model state
  int m_st = 0;  // 0 idle, 1 run, 2 drain
  int m_pos = 0;
  int a_f = 0, a_s = 0, a_r = 0;
  int m_err = 0;

  // observed-frame tracking
  int prev_b = 0, prev_f = 0;
  int rises = 0, last_rises = 0, cyc = 0, last_len = 0;
  int s_bhi = 0;

  audclk_ratio_gen u0 (
    .mclk_i(mclk), .rst_ni(rst_n), .fmt_i(fmt), .spd_i(spd), .rsel_i(rsel),
    .bclk_o(bclk), .fclk_o(fclk), .err_o(err)
  );

  always #(CLK_P/2) mclk = ~mclk;

  function automatic int m_legal(int f, int s, int r);
    if (f > 4 || s > 2 || r > 4) return 0;
    if (f >= 3 && s == 2) return 0;
    if (f >= 3 && s == 1 && r < 2) return 0;
    return 1;
  endfunction

  function automatic int m_ratio(int s, int r);
    int mult2[5] = '{2, 3, 4, 6, 8};
    return ((256 >> s) * mult2[r]) / 2;
  endfunction

  function automatic int m_bits(int f);
    return (f == 3) ? 128 : (f == 4) ? 256 : 64;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic model_edge();
    int f = int'(fmt), s = int'(spd), r = int'(rsel);
    int lg = m_legal(f, s, r);
    if (!rst_n) begin
      m_st = 0; m_pos = 0; m_err = 0; a_f = 0; a_s = 0; a_r = 0;
      return;
    end
    m_err = lg ? 0 : 1;
    if (m_st == 0) begin
      a_f = f; a_s = s; a_r = r; m_pos = 0; m_st = lg ? 1 : 0;
    end else begin
      int rr = m_ratio(a_s, a_r);
      int chg = (f != a_f || s != a_s || r != a_r) ? 1 : 0;
      if (m_pos == rr - 1 && (m_st == 2 || chg == 1)) begin
        a_f = f; a_s = s; a_r = r; m_pos = 0; m_st = lg ? 1 : 0;
      end else begin
        m_pos = (m_pos + 1) % rr;
        if (m_st == 1 && chg == 1) m_st = 2;
      end
    end
  endtask

  task automatic compare(string tag, int high);
    int eb = 0, ef = 0;
    if (m_st == 1) begin
      int rr = m_ratio(a_s, a_r);
      int p = 2 * rr / m_bits(a_f);
      int h = (2 * m_pos + (high ? 0 : 1)) % p;
      eb = (h < (p + 1) / 2) ? 1 : 0;
      ef = (m_pos >= rr / 2) ? 1 : 0;
    end
    chk(tag, high ? "bclk(hi phase)" : "bclk(lo phase)", int'(bclk), eb);
    chk(tag, "fclk", int'(fclk), ef);
    chk(tag, "err", int'(err), m_err);
  endtask

  task automatic track(int high);
    int b = int'(bclk), f = int'(fclk);
    int r = (b == 1 && prev_b == 0) ? 1 : 0;
    if (high) begin
      s_bhi = b;
      if (f == 0 && prev_f == 1) begin
        last_rises = rises; rises = r; last_len = cyc; cyc = 1;
      end else begin
        rises += r; cyc++;
      end
      prev_f = f;
    end else begin
      rises += r;
    end
    prev_b = b;
  endtask

  task automatic step(string tag);
    @(posedge mclk);
    model_edge();
    #(CLK_P/4);
    compare(tag, 1);
    track(1);
    @(negedge mclk);
    #(CLK_P/4);
    compare(tag, 0);
    track(0);
  endtask

  task automatic set_cfg(int f, int s, int r);
    fmt = 3'(f); spd = 2'(s); rsel = 3'(r);
  endtask

  task automatic run(int n, string tag);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  task automatic frame_chk(string tag, int bits, int ratio);
    chk(tag, "bit clocks per frame", last_rises, bits);
    chk(tag, "frame length", last_len, ratio);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R11 reset state
    set_cfg(0, 0, 0);
    run(3, "R11");
    chk("R11", "bclk in reset", int'(bclk), 0);
    chk("R11", "fclk in reset", int'(fclk), 0);
    chk("R11", "err in reset", int'(err), 0);
    rst_n = 1'b1;

    // R1 R4: I2S single x1 -> 256, divide by 4
    run(3 * 256 + 2, "R1");
    frame_chk("R1", 64, 256);

    // R10 mid-frame change to left-justified single x1.5
    run(40, "R4");
    set_cfg(1, 0, 1);
    step("R10");
    chk("R10", "bclk muted after change", s_bhi, 0);
    run(3 * 384 + 300, "R10");
    frame_chk("R1", 64, 384);

    // R5: quad x1.5 -> 96, divide by 1.5
    set_cfg(2, 2, 1);
    run(4 * 96 + 400, "R5");
    frame_chk("R5", 64, 96);

    // R5: quad x3 -> 192, divide by 3
    set_cfg(0, 2, 3);
    run(4 * 192 + 100, "R5");
    frame_chk("R5", 64, 192);

    // R2: one-line mode 1, single x4 -> 1024
    set_cfg(3, 0, 4);
    run(3 * 1024 + 200, "R2");
    frame_chk("R2", 128, 1024);

    // R2: one-line mode 2, double x3 -> 384, divide by 1.5
    set_cfg(4, 1, 3);
    run(3 * 384 + 1100, "R2");
    frame_chk("R2", 256, 384);

    // R6 R8 R9: one-line mode in quad speed
    set_cfg(4, 2, 4);
    run(400, "R6");
    step("R8");
    chk("R6", "err for one-line quad", int'(err), 1);
    chk("R9", "fclk idle on error", int'(fclk), 0);
    set_cfg(3, 1, 1);
    step("R8");
    chk("R6", "err for one-line double x1.5", int'(err), 1);
    run(10, "R9");

    // R7: TDM, reserved speed, reserved ratio
    set_cfg(5, 0, 0);
    step("R7");
    chk("R7", "err for TDM", int'(err), 1);
    set_cfg(0, 3, 0);
    step("R7");
    chk("R7", "err for reserved speed", int'(err), 1);
    set_cfg(1, 0, 5);
    step("R7");
    chk("R7", "err for reserved ratio", int'(err), 1);
    run(5, "R9");

    // R3: recovery into right-justified double x2 -> 256
    set_cfg(2, 1, 2);
    step("R8");
    chk("R8", "err cleared", int'(err), 0);
    run(3 * 256 + 10, "R3");
    frame_chk("R3", 64, 256);

    // R3: one-line mode 2, single x3 -> 768
    set_cfg(4, 0, 3);
    run(3 * 768 + 300, "R3");
    frame_chk("R3", 256, 768);

    // R10: change seen on the final cycle of a frame
    while (m_pos != m_ratio(a_s, a_r) - 1) step("R10");
    set_cfg(0, 2, 0);
    step("R10");
    chk("R10", "no gap at boundary switch", s_bhi, 1);
    chk("R10", "frame restarts low", int'(fclk), 0);
    run(3 * 64 + 5, "R10");
    frame_chk("R10", 64, 64);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule